// File: doc/BRIEF.md
# Burst Memory Read-Data Output Stage

This block is the read-data output path of a synchronous burst memory. Each clock it takes a cycle-type code from the command decoder and read data from the internal array. It drives a data bus with one output-enable bit per data bit. A mode selection chooses between two timings. In pipelined operation the array data passes through a rising-edge output register. In flow-through operation the data reaches the bus in the cycle the array delivers it.

The drivers stop only after a deselect has passed through the same pipeline depth as a read. The bus therefore stays on for one full cycle after the deselect is sampled, and goes quiet after the second edge. An asynchronous active-low output enable can silence the bus at any moment. A read made with that enable high is a dummy read: it advances like any other read but puts nothing on the bus. A write command on the input silences the bus in its own cycle.

A sleep request takes effect two edges after it is sampled. While asleep, the drivers are off, every command is discarded and the output register keeps its contents. After wake-up there is a recovery window of a parameterised number of cycles. In that window a write is refused, handled as a deselect, and reported on an error output.

Top module: `burst_rdout_stage`

## Requirements
- R1: After a synchronous reset (active-high `rst`), and until a read has been sampled, `dq_oe` and `dq_out` are all zero and `wr_rec_err` is low.
- R2: Command codes on `cyc_cmd` are 0 deselect, 1 read and 2 write. In pipelined operation, a read sampled at edge k drives, in the cycle after edge k+1, the `arr_rdata` value that was present in the cycle after edge k. Back-to-back reads deliver one beat per cycle.
- R3: In flow-through operation, a read sampled at edge k drives the live `arr_rdata` value throughout the cycle after edge k.
- R4: With `pipe_sel_drv` high, `pipe_sel` selects the mode (1 pipelined, 0 flow-through). With `pipe_sel_drv` low, the mode is taken from parameter DEFAULT_PIPE, which defaults to pipelined.
- R5: When a deselect sampled at edge d follows a read, the drivers stay on through the cycle after edge d and turn off after edge d+1. In flow-through operation the extra cycle holds the last read data.
- R6: `oe_n` acts without the clock. While it is high every `dq_oe` bit is zero. Taking it low turns the drivers on only in a cycle that delivers read data.
- R7: In a cycle whose `cyc_cmd` is a write, and in a cycle that delivers the pipeline slot of a write, all `dq_oe` bits are zero. In a read delivery cycle all lanes drive together.
- R8: Command code 3 behaves exactly as a deselect.
- R9: A read whose delivery cycle sees `oe_n` high drives nothing. The pipeline still advances, so later reads deliver on their normal schedule.
- R10: If `sleep_req` is sampled high at edge k, the block is asleep during the cycle after edge k+1. While asleep, all `dq_oe` bits are zero, and any command sampled then is treated as a deselect.
- R11: When sleep ends, the block enters a recovery window of REC_CYCLES cycles. A write sampled in this window is treated as a deselect, so in flow-through operation a preceding read gets its hold cycle. That write also makes `wr_rec_err` high for exactly the next cycle. Writes outside the window never raise `wr_rec_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_cmd | input | 2 | Cycle type from the command decoder (0 deselect, 1 read, 2 write, 3 deselect) |
| arr_rdata | input | LANES*LANE_W | Read data from the array, valid in the cycle after the read is sampled |
| pipe_sel | input | 1 | Mode choice: 1 pipelined, 0 flow-through |
| pipe_sel_drv | input | 1 | High when `pipe_sel` is driven; low selects the DEFAULT_PIPE parameter |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Sleep request, active high |
| dq_out | output | LANES*LANE_W | Output data, zero while not driving |
| dq_oe | output | LANES*LANE_W | Per-bit driver enable |
| wr_rec_err | output | 1 | One-cycle flag for a write refused during sleep recovery |

## Verification
The bench builds the block with two lanes of four bits and a recovery window of three cycles. This keeps the data bus at one byte, so a distinct pattern can be placed on the array data every cycle, and makes the recovery window short enough that random sleep pulses often catch writes inside it and just after it. The bench sweeps every three-command combination, including the spare code, in both modes and under the parameter default. It also sweeps every output-enable pattern across a read burst. Long pseudo-random runs then mix sleep, dummy reads and writes. A spec-level model in the bench computes the expected drive, data and error flag for every cycle.

// File: rtl/rdo_pkg.sv
`timescale 1ns/1ps
package rdo_pkg;

    // Cycle-type codes as decoded from the command input.
    typedef enum logic [1:0] {
        CYC_DESEL = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2,
        CYC_RSVD  = 2'd3
    } cyc_e;

    // Edges between a sampled sleep request and the asleep state.
    localparam int unsigned SLEEP_LAG = 2;

    // The spare code collapses onto deselect.
    function automatic cyc_e norm_cmd(input logic [1:0] code);
        return (code == 2'd3) ? CYC_DESEL : cyc_e'(code);
    endfunction

    // Width of a down-counter that must hold the value n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rdo_sleep_ctl.sv
module rdo_sleep_ctl
    import rdo_pkg::*;
#(
    parameter int unsigned REC_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    input  cyc_e cmd_now,
    output logic asleep,
    output logic in_rec,
    output logic wr_rec_err
);
    localparam int unsigned CW = cnt_width(REC_CYCLES);
    localparam logic [CW-1:0] REC_LOAD = CW'(REC_CYCLES);

    logic [SLEEP_LAG-1:0] zz_pipe;
    logic [CW-1:0]        rec_cnt;

    // Sleep request delay line; the last stage is the asleep state.
    always_ff @(posedge clk) begin
        if (rst) begin
            zz_pipe <= '0;
        end else begin
            zz_pipe <= {zz_pipe[SLEEP_LAG-2:0], sleep_req};
        end
    end

    assign asleep = zz_pipe[SLEEP_LAG-1];

    // Recovery window: reloaded on every asleep cycle, drains after wake.
    always_ff @(posedge clk) begin
        if (rst) begin
            rec_cnt    <= '0;
            wr_rec_err <= 1'b0;
        end else begin
            if (asleep) begin
                rec_cnt <= REC_LOAD;
            end else if (rec_cnt != '0) begin
                rec_cnt <= rec_cnt - CW'(1);
            end
            wr_rec_err <= in_rec && (cmd_now == CYC_WRITE);
        end
    end

    assign in_rec = !asleep && (rec_cnt != '0);

    assert_sleep_lag_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(asleep) |-> $past(sleep_req, 2));

    assert_err_source_R11: assert property (@(posedge clk) disable iff (rst)
        wr_rec_err |-> ($past(cmd_now) == CYC_WRITE) && !$past(asleep));

    assert_wake_recovers_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(asleep) |-> in_rec);

endmodule

// File: rtl/rdo_cmd_pipe.sv
module rdo_cmd_pipe
    import rdo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cyc_e cmd_now,
    input  logic asleep,
    input  logic in_rec,
    output cyc_e s1_kind,
    output cyc_e s2_kind
);
    cyc_e cmd_acc;

    // Commands are discarded while asleep; writes are refused in recovery.
    always_comb begin
        if (asleep || (in_rec && (cmd_now == CYC_WRITE))) begin
            cmd_acc = CYC_DESEL;
        end else begin
            cmd_acc = cmd_now;
        end
    end

    // Two-deep cycle-type pipeline: a deselect travels as far as a read.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_kind <= CYC_DESEL;
            s2_kind <= CYC_DESEL;
        end else begin
            s1_kind <= cmd_acc;
            s2_kind <= s1_kind;
        end
    end

    assert_rec_blocks_write_R11: assert property (@(posedge clk) disable iff (rst)
        (s1_kind == CYC_WRITE) |-> !$past(asleep) && !$past(in_rec));

    assert_no_read_from_sleep_R10: assert property (@(posedge clk) disable iff (rst)
        (s2_kind == CYC_READ) |-> !$past(asleep, 2));

endmodule

// File: rtl/rdo_out_path.sv
module rdo_out_path
    import rdo_pkg::*;
#(
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pipe_eff,
    input  cyc_e                    s1_kind,
    input  cyc_e                    s2_kind,
    input  logic [LANES*LANE_W-1:0] arr_rdata,
    output logic                    drive_sync,
    output logic [LANES*LANE_W-1:0] data_sel
);
    localparam int unsigned DW = LANES * LANE_W;

    logic ft_live;
    logic ft_hold;

    assign ft_live = (s1_kind == CYC_READ);
    assign ft_hold = (s1_kind == CYC_DESEL) && (s2_kind == CYC_READ);

    // Clocked drive decision before the asynchronous gates.
    always_comb begin
        if (pipe_eff) begin
            drive_sync = (s2_kind == CYC_READ);
        end else begin
            drive_sync = ft_live || ft_hold;
        end
    end

    // Per-lane output register and bypass mux.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q <= '0;
            end else if (ft_live) begin
                lane_q <= arr_rdata[l*LANE_W +: LANE_W];
            end
        end

        assign data_sel[l*LANE_W +: LANE_W] =
            (!pipe_eff && ft_live) ? arr_rdata[l*LANE_W +: LANE_W] : lane_q;
    end

    assert_dcd_hold_once_R5: assert property (@(posedge clk) disable iff (rst)
        (drive_sync && !pipe_eff && (s1_kind != CYC_READ))
            |=> !drive_sync || (s1_kind == CYC_READ));

    assert_pipe_data_R2: assert property (@(posedge clk) disable iff (rst)
        (pipe_eff && drive_sync) |-> (data_sel == $past(arr_rdata)));

    initial assert (DW > 0) else $error("empty data path");

endmodule

// File: rtl/burst_rdout_stage.sv
module burst_rdout_stage
    import rdo_pkg::*;
#(
    parameter int unsigned LANES        = 4,
    parameter int unsigned LANE_W       = 9,
    parameter int unsigned REC_CYCLES   = 8,
    parameter bit          DEFAULT_PIPE = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              cyc_cmd,
    input  logic [LANES*LANE_W-1:0] arr_rdata,
    input  logic                    pipe_sel,
    input  logic                    pipe_sel_drv,
    input  logic                    oe_n,
    input  logic                    sleep_req,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic [LANES*LANE_W-1:0] dq_oe,
    output logic                    wr_rec_err
);
    localparam int unsigned DW = LANES * LANE_W;

    cyc_e          cmd_now;
    cyc_e          s1_kind;
    cyc_e          s2_kind;
    logic          pipe_eff;
    logic          asleep;
    logic          in_rec;
    logic          drive_sync;
    logic          bus_on;
    logic [DW-1:0] data_sel;

    assign cmd_now  = norm_cmd(cyc_cmd);
    assign pipe_eff = pipe_sel_drv ? pipe_sel : DEFAULT_PIPE;

    rdo_sleep_ctl #(
        .REC_CYCLES(REC_CYCLES)
    ) u_sleep (
        .clk        (clk),
        .rst        (rst),
        .sleep_req  (sleep_req),
        .cmd_now    (cmd_now),
        .asleep     (asleep),
        .in_rec     (in_rec),
        .wr_rec_err (wr_rec_err)
    );

    rdo_cmd_pipe u_pipe (
        .clk     (clk),
        .rst     (rst),
        .cmd_now (cmd_now),
        .asleep  (asleep),
        .in_rec  (in_rec),
        .s1_kind (s1_kind),
        .s2_kind (s2_kind)
    );

    rdo_out_path #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_path (
        .clk        (clk),
        .rst        (rst),
        .pipe_eff   (pipe_eff),
        .s1_kind    (s1_kind),
        .s2_kind    (s2_kind),
        .arr_rdata  (arr_rdata),
        .drive_sync (drive_sync),
        .data_sel   (data_sel)
    );

    // Asynchronous gates: output enable, live write, sleep.
    assign bus_on = drive_sync && !oe_n && !asleep && (cmd_now != CYC_WRITE);

    for (genvar l = 0; l < LANES; l++) begin : g_drv
        assign dq_oe[l*LANE_W +: LANE_W]  = {LANE_W{bus_on}};
        assign dq_out[l*LANE_W +: LANE_W] = bus_on ? data_sel[l*LANE_W +: LANE_W] : '0;
    end

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (pipe_eff && dq_oe[0]) |-> ($past(cyc_cmd, 2) == 2'd1));

    assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst, 2) && $past(sleep_req, 2)) |-> (dq_oe == '0));

endmodule

// File: tb/tb_burst_rdout_stage.sv
`timescale 1ns/1ps
module tb_burst_rdout_stage;

    localparam int LANES  = 2;
    localparam int LANE_W = 4;
    localparam int DW     = LANES * LANE_W;
    localparam int REC    = 3;
    localparam int MAXC   = 16384;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cyc_cmd = 2'd0;
    logic [DW-1:0] arr_rdata = '0;
    logic          pipe_sel = 1'b1;
    logic          pipe_sel_drv = 1'b1;
    logic          oe_n = 1'b0;
    logic          sleep_req = 1'b0;
    logic [DW-1:0] dq_out;
    logic [DW-1:0] dq_oe;
    logic          wr_rec_err;

    burst_rdout_stage #(
        .LANES(LANES), .LANE_W(LANE_W), .REC_CYCLES(REC)
    ) dut (
        .clk(clk), .rst(rst), .cyc_cmd(cyc_cmd), .arr_rdata(arr_rdata),
        .pipe_sel(pipe_sel), .pipe_sel_drv(pipe_sel_drv), .oe_n(oe_n),
        .sleep_req(sleep_req), .dq_out(dq_out), .dq_oe(dq_oe),
        .wr_rec_err(wr_rec_err)
    );

    always #2 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cur   = 0;
    int base  = 0;
    bit rel_pending = 1'b0;
    bit mode_pipe = 1'b1;
    bit mode_dflt = 1'b0;
    bit done = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    int            h_cmd  [MAXC];
    int            h_conv [MAXC];
    int            h_rec  [MAXC];
    bit            h_sl   [MAXC];
    bit            h_asl  [MAXC];
    bit            h_inrec[MAXC];
    logic [DW-1:0] h_dat  [MAXC];

    logic [DW-1:0] last_oe;
    logic [DW-1:0] last_out;

    function automatic int conv_at(int i);
        return (i < base) ? 0 : h_conv[i];
    endfunction

    function automatic logic [31:0] next_rng(logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle %0d %s: actual %h expected %h", tag, cur, what, act, exp);
        end
    endtask

    task automatic do_reset(input bit drv, input bit sel);
        @(negedge clk);
        rst = 1'b1; cyc_cmd = 2'd0; oe_n = 1'b0; sleep_req = 1'b0;
        pipe_sel_drv = drv; pipe_sel = sel;
        mode_pipe = drv ? sel : 1'b1;
        mode_dflt = !drv;
        repeat (5) @(negedge clk);
        rel_pending = 1'b1;
    endtask

    // One clock cycle: drive inputs after the falling edge, model, compare.
    task automatic step(input int c, input bit o, input bit s);
        bit asl, inrec, son, on, hold, e_err;
        int rec, cv;
        logic [DW-1:0] sdat, e_oe, e_out;
        string tag;
        if (!rel_pending) @(negedge clk);
        if (rel_pending) begin
            rst = 1'b0; base = cur; rel_pending = 1'b0;
        end
        cyc_cmd = c[1:0]; oe_n = o; sleep_req = s;
        arr_rdata = DW'(cur * 37 + 11);
        h_cmd[cur] = c; h_sl[cur] = s; h_dat[cur] = arr_rdata;
        asl = (cur - 2 >= base) ? h_sl[cur-2] : 1'b0;
        if (cur - 1 < base) rec = 0;
        else if (h_asl[cur-1]) rec = REC;
        else rec = (h_rec[cur-1] > 0) ? h_rec[cur-1] - 1 : 0;
        inrec = !asl && (rec > 0);
        h_asl[cur] = asl; h_rec[cur] = rec; h_inrec[cur] = inrec;
        if (asl || c == 3 || (c == 2 && inrec)) cv = 0; else cv = c;
        h_conv[cur] = cv;
        hold = 1'b0; son = 1'b0; sdat = '0;
        if (mode_pipe) begin
            son  = (conv_at(cur - 2) == 1);
            sdat = (cur - 1 >= base) ? h_dat[cur-1] : '0;
        end else if (conv_at(cur - 1) == 1) begin
            son = 1'b1; sdat = h_dat[cur];
        end else if (conv_at(cur - 1) == 0 && conv_at(cur - 2) == 1) begin
            son = 1'b1; hold = 1'b1; sdat = h_dat[cur-1];
        end
        on    = son && !o && (c != 2) && !asl;
        e_oe  = on ? '1 : '0;
        e_out = on ? sdat : '0;
        e_err = (cur - 1 >= base) && (h_cmd[cur-1] == 2) && h_inrec[cur-1];
        if (cur == base) tag = "R1";
        else if (asl || h_asl[cur-1]) tag = "R10";
        else if (son && o) tag = "R9";
        else if (c == 2) tag = "R7";
        else if (mode_dflt) tag = "R4";
        else if (hold) tag = "R5";
        else if ((cur - 2 >= base) && (h_cmd[cur-1] == 3 || h_cmd[cur-2] == 3)) tag = "R8";
        else if (mode_pipe) tag = "R2";
        else tag = "R3";
        #1;
        check((dq_oe == e_oe) && (dq_out == e_out), tag, "bus {oe,out}",
              {16'h0, dq_oe, dq_out}, {16'h0, e_oe, e_out});
        check(wr_rec_err == e_err, (cur == base) ? "R1" : "R11", "wr_rec_err",
              32'(wr_rec_err), 32'(e_err));
        last_oe = e_oe; last_out = e_out;
        if (cur < MAXC - 1) cur++;
    endtask

    // R6: toggle the output enable inside a delivery cycle, no clock edge.
    task automatic oe_probe();
        oe_n = 1'b1;
        #0.3;
        check(dq_oe == '0, "R6", "oe_n high mid-cycle", 32'(dq_oe), 32'h0);
        oe_n = 1'b0;
        #0.3;
        check((dq_oe == last_oe) && (dq_out == last_out) && (last_oe == '1), "R6",
              "oe_n low mid-cycle", {16'h0, dq_oe, dq_out}, {16'h0, last_oe, last_out});
    endtask

    initial begin
        // Three-command sweep in each mode, including the parameter default.
        for (int m = 0; m < 3; m++) begin
            do_reset(m != 2, m == 0);
            step(0, 0, 0);
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++)
                    for (int c = 0; c < 4; c++) begin
                        step(a, 0, 0); step(b, 0, 0); step(c, 0, 0);
                        step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
                    end
        end
        // Output-enable patterns across a read burst (dummy reads, R9).
        for (int m = 0; m < 2; m++) begin
            do_reset(1'b1, m == 0);
            step(0, 0, 0);
            for (int k = 0; k < 16; k++) begin
                step(1, k[0], 0); step(1, k[1], 0); step(1, k[2], 0);
                step(2, k[3], 0); step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
            end
        end
        // R6 asynchronous enable, pipelined then flow-through.
        do_reset(1'b1, 1'b1);
        step(0, 0, 0); step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
        oe_probe();
        step(0, 0, 0);
        do_reset(1'b1, 1'b0);
        step(0, 0, 0); step(1, 0, 0); step(0, 0, 0);
        oe_probe();
        step(0, 0, 0);
        // R11 directed: write right after wake in flow-through, then clean write.
        do_reset(1'b1, 1'b0);
        step(0, 0, 0);
        repeat (4) step(1, 0, 1);
        step(1, 0, 0); step(1, 0, 0);
        step(1, 0, 0); step(2, 0, 0); step(0, 0, 0);
        step(2, 0, 0); step(0, 0, 0); step(2, 0, 0); step(0, 0, 0); step(0, 0, 0);
        // Long mixed runs with sleep pulses in each mode.
        for (int m = 0; m < 3; m++) begin
            bit slp = 1'b0;
            do_reset(m != 2, m == 0);
            step(0, 0, 0);
            for (int i = 0; i < 2500; i++) begin
                rng = next_rng(rng);
                if (rng[11:8] == 4'd0) slp = !slp;
                step(int'(rng[1:0]), rng[5:4] == 2'd0, slp);
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule